// File: doc/BRIEF.md
# Paged and Indirect Data Address Generator

This block produces the 16-bit operand address used by a small signal-processing core to reach data memory. The core can reach memory in two ways. In paged mode, a 9-bit page register sits above a 7-bit offset field taken from the instruction, so memory is seen as 512 pages of 128 words each. In pointer mode, the address is the contents of one of eight 16-bit pointer registers. A 3-bit selector register chooses which pointer is used.

After a pointer is used, it can be stepped up or down by one. The page register, the selector and any pointer can each be loaded from the decoder. The result is registered: the address and its valid flag appear one clock after the request. The two non-memory addressing modes give no address, and the valid flag stays low for them.

Top module: `dag_agen`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) drives `valid_o` and `addr_o` to zero. It also clears the page register, the selector and all eight pointers, so that a first paged access returns `{9'd0, offset}` and a first pointer access returns 0.
- R2: A paged access (`req_i`=1, `mode_i`=2'b00) gives `addr_o` = {page register, `ofs_i`}. The page sits in bits 15:7 and the offset sits in bits 6:0. The offset never carries into the page bits.
- R3: A pointer access (`req_i`=1, `mode_i`=2'b01) gives `addr_o` equal to the pointer chosen by the selector.
- R4: A selector value k (0 to 7) picks pointer k.
- R5: In modes 2'b10 and 2'b11, and whenever `req_i` is low, `valid_o` is low the next cycle and `addr_o` keeps its previous value.
- R6: During a pointer access, `post_i` steps the chosen pointer after use. The codes are: 2'b01 adds one, 2'b10 subtracts one, 2'b00 and 2'b11 leave it unchanged. The step wraps modulo 2^16.
- R7: The selector may be reloaded in the same cycle as a pointer access. That access uses the old selector, and the new value applies from the next access.
- R8: A pointer load (`ar_ld_i`, `ar_idx_i`, `ar_din_i`) that targets the same pointer as a post-step in the same cycle wins. A load to a different pointer and the post-step both take effect.
- R9: Loads of the page register, the selector and the pointers take effect at the next clock edge. An access in the same cycle as a load sees the old value.
- R10: `valid_o` is high exactly one cycle after a request in mode 2'b00 or 2'b01, and `addr_o` is updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Address request for this cycle |
| mode_i | input | 2 | 00 paged, 01 pointer, 10 and 11 non-memory |
| ofs_i | input | 7 | Offset field from the instruction |
| post_i | input | 2 | Post-step: 01 add one, 10 subtract one, else none |
| pg_ld_i | input | 1 | Load the page register |
| pg_din_i | input | 9 | New page value |
| sel_ld_i | input | 1 | Load the pointer selector |
| sel_din_i | input | 3 | New selector value |
| ar_ld_i | input | 1 | Load one pointer register |
| ar_idx_i | input | 3 | Index of the pointer to load |
| ar_din_i | input | 16 | Value to load into the pointer |
| addr_o | output | 16 | Registered operand address |
| valid_o | output | 1 | `addr_o` carries a new address |

## Verification
Two updates can land on one pointer in the same cycle: the post-step of a pointer access, and an explicit load from the decoder. The bench provokes this by issuing stepped accesses while loading either the selected pointer or a different one. It then reads the pointer back with a plain access and judges the result against a model in which the load wins on a match and both updates apply otherwise. The selector reload during an access is handled the same way: the address returned must come from the old selector, and the next access must use the new one.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef enum logic [1:0] {
    AM_PAGED   = 2'b00,
    AM_POINTER = 2'b01,
    AM_IMMED   = 2'b10,
    AM_REGOP   = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    PS_NONE = 2'b00,
    PS_INC  = 2'b01,
    PS_DEC  = 2'b10,
    PS_HOLD = 2'b11
  } post_e;

  function automatic logic is_mem_mode(input logic [1:0] m);
    return (m == AM_PAGED) || (m == AM_POINTER);
  endfunction

endpackage

// File: rtl/dag_page_reg.sv
module dag_page_reg #(
  parameter int PAGE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] din_i,
  output logic [PAGE_W-1:0] page_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      page_o <= '0;
    end else if (ld_i) begin
      page_o <= din_i;
    end
  end

endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file
  import dag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_AR = 8,
  localparam int SEL_W = $clog2(NUM_AR)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_ld_i,
  input  logic [SEL_W-1:0]  sel_din_i,
  input  logic              ar_ld_i,
  input  logic [SEL_W-1:0]  ar_idx_i,
  input  logic [ADDR_W-1:0] ar_din_i,
  input  logic              step_en_i,
  input  logic [1:0]        step_op_i,
  output logic [ADDR_W-1:0] rd_data_o
);

  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] ar_q [NUM_AR];

  // Selector: a load applies at the edge, so the current access uses the old value.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q <= '0;
    end else if (sel_ld_i) begin
      sel_q <= sel_din_i;
    end
  end

  for (genvar g = 0; g < NUM_AR; g++) begin : g_ar
    logic [ADDR_W-1:0] reg_q;
    logic              hit_ld;
    logic              hit_step;

    assign hit_ld   = ar_ld_i && (ar_idx_i == SEL_W'(g));
    assign hit_step = step_en_i && (sel_q == SEL_W'(g));

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        reg_q <= '0;
      end else if (hit_ld) begin
        reg_q <= ar_din_i;                 // explicit load has priority
      end else if (hit_step) begin
        case (step_op_i)
          PS_INC:  reg_q <= reg_q + ADDR_W'(1);
          PS_DEC:  reg_q <= reg_q - ADDR_W'(1);
          default: reg_q <= reg_q;
        endcase
      end
    end

    assign ar_q[g] = reg_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_AR; i++) begin
      if (sel_q == SEL_W'(i)) rd_data_o = ar_q[i];
    end
  end

endmodule

// File: rtl/dag_addr_out.sv
module dag_addr_out
  import dag_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFFS_W = 7,
  localparam int ADDR_W = PAGE_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic [1:0]        mode_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFFS_W-1:0] ofs_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i && is_mem_mode(mode_i);
      if (req_i && (mode_i == AM_PAGED)) begin
        addr_o <= {page_i, ofs_i};
      end else if (req_i && (mode_i == AM_POINTER)) begin
        addr_o <= ptr_i;
      end
    end
  end

endmodule

// File: rtl/dag_agen.sv
module dag_agen
  import dag_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFFS_W = 7,
  parameter int NUM_AR = 8,
  localparam int ADDR_W = PAGE_W + OFFS_W,
  localparam int SEL_W  = $clog2(NUM_AR)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic [1:0]        mode_i,
  input  logic [OFFS_W-1:0] ofs_i,
  input  logic [1:0]        post_i,
  input  logic              pg_ld_i,
  input  logic [PAGE_W-1:0] pg_din_i,
  input  logic              sel_ld_i,
  input  logic [SEL_W-1:0]  sel_din_i,
  input  logic              ar_ld_i,
  input  logic [SEL_W-1:0]  ar_idx_i,
  input  logic [ADDR_W-1:0] ar_din_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);

  logic [PAGE_W-1:0] page_w;
  logic [ADDR_W-1:0] ptr_w;
  logic              step_en_w;

  assign step_en_w = req_i && (mode_i == AM_POINTER);

  dag_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ld_i   (pg_ld_i),
    .din_i  (pg_din_i),
    .page_o (page_w)
  );

  dag_ptr_file #(.ADDR_W(ADDR_W), .NUM_AR(NUM_AR)) u_ptrs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sel_ld_i  (sel_ld_i),
    .sel_din_i (sel_din_i),
    .ar_ld_i   (ar_ld_i),
    .ar_idx_i  (ar_idx_i),
    .ar_din_i  (ar_din_i),
    .step_en_i (step_en_w),
    .step_op_i (post_i),
    .rd_data_o (ptr_w)
  );

  dag_addr_out #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_out (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (req_i),
    .mode_i  (mode_i),
    .page_i  (page_w),
    .ofs_i   (ofs_i),
    .ptr_i   (ptr_w),
    .addr_o  (addr_o),
    .valid_o (valid_o)
  );

endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int OFFS_W = 7,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              req_i,
  input logic [1:0]        mode_i,
  input logic [OFFS_W-1:0] ofs_i,
  input logic [1:0]        post_i,
  input logic              sel_ld_i,
  input logic              ar_ld_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              valid_o
);

  logic mem_req;
  logic ptr_clean;
  logic ptr_inc;
  logic ptr_dec;

  assign mem_req   = req_i && (mode_i[1] == 1'b0);
  assign ptr_clean = req_i && (mode_i == 2'b01) && !sel_ld_i && !ar_ld_i;
  assign ptr_inc   = ptr_clean && (post_i == 2'b01);
  assign ptr_dec   = ptr_clean && (post_i == 2'b10);

  // R1
  reset_clears_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!valid_o && (addr_o == '0)));

  // R10
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (valid_o == $past(mem_req)));

  // R2
  paged_offset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && mode_i == 2'b00) |=> (addr_o[OFFS_W-1:0] == $past(ofs_i)));

  // R5
  nonmem_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !mem_req |=> (!valid_o && $stable(addr_o)));

  // R6
  post_inc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ptr_clean && $past(ptr_inc) && !$past(rst_i)) |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

  // R6
  post_dec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ptr_clean && $past(ptr_dec) && !$past(rst_i)) |=> (addr_o == $past(addr_o) - ADDR_W'(1)));

endmodule

bind dag_agen dag_chk #(.OFFS_W(OFFS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .req_i    (req_i),
  .mode_i   (mode_i),
  .ofs_i    (ofs_i),
  .post_i   (post_i),
  .sel_ld_i (sel_ld_i),
  .ar_ld_i  (ar_ld_i),
  .addr_o   (addr_o),
  .valid_o  (valid_o)
);

// File: tb/dag_agen_test.sv
`timescale 1ns/1ps
module dag_agen_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [1:0]  mode;
  logic [6:0]  ofs;
  logic [1:0]  post;
  logic        pg_ld;
  logic [8:0]  pg_din;
  logic        sel_ld;
  logic [2:0]  sel_din;
  logic        ar_ld;
  logic [2:0]  ar_idx;
  logic [15:0] ar_din;
  logic [15:0] addr;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model
  logic [8:0]  m_pg;
  logic [2:0]  m_sel;
  logic [15:0] m_ar [8];
  logic [15:0] e_addr;
  logic        e_valid;

  always #10 clk = ~clk;

  dag_agen uut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .mode_i(mode), .ofs_i(ofs),
    .post_i(post), .pg_ld_i(pg_ld), .pg_din_i(pg_din), .sel_ld_i(sel_ld),
    .sel_din_i(sel_din), .ar_ld_i(ar_ld), .ar_idx_i(ar_idx), .ar_din_i(ar_din),
    .addr_o(addr), .valid_o(valid)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req = 0; mode = 0; ofs = 0; post = 0; pg_ld = 0; pg_din = 0;
    sel_ld = 0; sel_din = 0; ar_ld = 0; ar_idx = 0; ar_din = 0;
  endtask

  // Apply one cycle of stimulus, advance the model, then compare after the edge.
  task automatic step(string tag, logic r, logic [1:0] md, logic [6:0] of, logic [1:0] ps,
                      logic pl, logic [8:0] pd, logic sl, logic [2:0] sd,
                      logic al, logic [2:0] ai, logic [15:0] ad);
    req = r; mode = md; ofs = of; post = ps; pg_ld = pl; pg_din = pd;
    sel_ld = sl; sel_din = sd; ar_ld = al; ar_idx = ai; ar_din = ad;
    e_valid = r && (md[1] == 1'b0);
    if (r && md == 2'b00) e_addr = {m_pg, of};
    if (r && md == 2'b01) begin
      e_addr = m_ar[m_sel];
      if (ps == 2'b01) m_ar[m_sel] = m_ar[m_sel] + 16'd1;
      if (ps == 2'b10) m_ar[m_sel] = m_ar[m_sel] - 16'd1;
    end
    if (al) m_ar[ai] = ad;  // load overrides step (R8)
    if (pl) m_pg = pd;
    if (sl) m_sel = sd;
    @(posedge clk);
    #1;
    chk({tag, " valid"}, {15'd0, valid}, {15'd0, e_valid});
    chk({tag, " addr"}, addr, e_addr);
  endtask

  task automatic rd_ptr(string tag);
    step(tag, 1, 2'b01, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    m_pg = 0; m_sel = 0; e_addr = 0; e_valid = 0;
    for (int k = 0; k < 8; k++) m_ar[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the outputs
    chk("R1 valid", {15'd0, valid}, 16'd0);
    chk("R1 addr", addr, 16'd0);
    rst = 0;
    step("R1 page", 1, 2'b00, 7'h55, 0, 0, 0, 0, 0, 0, 0, 0);
    rd_ptr("R1 ptr");

    // R2 and R9: sweep every page, loading the next page during each access
    for (int p = 0; p < 512; p++) begin
      step("R9", 1, 2'b00, 7'(p * 3), 0, 1, 9'(p), 0, 0, 0, 0, 0);
      step("R2", 1, 2'b00, 7'h7F, 0, 0, 0, 0, 0, 0, 0, 0);
    end

    // R4: fill every pointer, then select each one in turn
    for (int k = 0; k < 8; k++)
      step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'(k), 16'(k * 16'h1111 + 16'h0F0F));
    for (int k = 0; k < 8; k++) begin
      step("R4", 0, 0, 0, 0, 0, 0, 1, 3'(k), 0, 0, 0);
      rd_ptr("R4");
      rd_ptr("R3");
    end

    // R7: selector reload during a pointer access uses the old selector
    step("R7", 1, 2'b01, 0, 2'b00, 0, 0, 1, 3'd2, 0, 0, 0);
    rd_ptr("R7");

    // R6: wrap both ways on pointer 3
    step("R6", 0, 0, 0, 0, 0, 0, 1, 3'd3, 1, 3'd3, 16'hFFFE);
    for (int k = 0; k < 3; k++) step("R6", 1, 2'b01, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) step("R6", 1, 2'b01, 0, 2'b10, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 2'b01, 0, 2'b11, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 2'b01, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    rd_ptr("R6");

    // R8: load and step on the same pointer, then on different pointers
    step("R8", 1, 2'b01, 0, 2'b01, 0, 0, 0, 0, 1, 3'd3, 16'h1234);
    rd_ptr("R8");
    step("R8", 1, 2'b01, 0, 2'b10, 0, 0, 0, 0, 1, 3'd5, 16'hBEEF);
    rd_ptr("R8");
    step("R8", 0, 0, 0, 0, 0, 0, 1, 3'd5, 0, 0, 0);
    rd_ptr("R8");

    // R5: non-memory modes and idle cycles hold the address
    step("R5", 1, 2'b10, 7'h11, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 2'b11, 7'h22, 2'b10, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 2'b00, 7'h33, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 2'b01, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    rd_ptr("R5");

    // R10: mixed sweep over modes, steps, loads and selectors
    for (int i = 0; i < 2048; i++) begin
      step("R10", (i % 3) != 0, 2'(i), 7'(i * 5), 2'(i >> 2),
           (i % 11) == 0, 9'(i * 7), (i % 7) == 0, 3'(i >> 4),
           (i % 5) == 0, 3'(i >> 1), 16'(i * 40503));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule